// File: doc/BRIEF.md
# Console Serial Register Interface

A memory-mapped register front end for a console serial port. Software reaches it over a simple word bus: one address, a read strobe, a write strobe, write data and combinational read data. Incoming characters arrive on a byte stream with valid/ready handshake and wait in a one-byte holding register. Outgoing characters leave as a one-cycle pulse on a byte output. Line serialisation and baud timing are handled elsewhere.

The block contains separate interrupt enables for the receive and transmit paths. When a source becomes active, the block latches a pending flag. That flag drives a level-2 interrupt request and one bit of a system status word. The block also presents a fixed vector byte for the source that raised the request. Software acknowledges the interrupt by writing either status register. A fixed identification register at offset 0x100 always reads 128.

Top module: `con_serial_regs`

## Requirements
- R1: A read of offset 0x080 returns bit 7 = a received byte is waiting and bit 6 = receive interrupt enable, with all other bits zero. A write there loads the enable from write-data bit 6. Bit 7 cannot be written.
- R2: A read of offset 0x084 returns the waiting byte in bits 7:0 and empties the holding register. When no byte is waiting, the read returns zero. Writes to 0x084 are ignored.
- R3: `rx_ready_o` is low while a byte is held, so further input bytes are not taken. It is high again in the cycle after a read of 0x084 that empties the holding register.
- R4: A read of offset 0x088 returns bit 7 = 1 (the transmitter is always ready) and bit 6 = transmit interrupt enable. A write there loads that enable from write-data bit 6.
- R5: A write to offset 0x08C produces `tx_valid_o` high for exactly the next cycle, with `tx_byte_o` equal to write-data bits 7:0.
- R6: When the receive enable is set and a byte is waiting, the interrupt request rises one cycle later with vector 0xF8.
- R7: Whenever the transmit enable is set, the interrupt request rises one cycle later with vector 0xFC. When both sources are active, 0xFC is presented.
- R8: The pending flag drives `irq_o` and bit 28 of `sys_stat_o`; all other status bits are zero. The flag stays set until a write to 0x080 or 0x088, which clears it on that edge. If a source is still active afterwards, the flag sets again one cycle later.
- R9: A read of offset 0x100 returns 128. Writes to it change nothing.
- R10: Reads of any other offset return zero, and writes to other offsets have no effect on any register or output.
- R11: After reset, `irq_o` is 0, `sys_stat_o` is 0, `tx_valid_o` is 0, `rx_ready_o` is 1 and both enables are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W (12) | Byte offset of the access |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data, valid during the read strobe |
| rx_byte_i | input | 8 | Incoming character |
| rx_valid_i | input | 1 | Incoming character valid |
| rx_ready_o | output | 1 | Holding register can accept a character |
| tx_byte_o | output | 8 | Outgoing character |
| tx_valid_o | output | 1 | Outgoing character strobe |
| irq_o | output | 1 | Level-2 interrupt request |
| irq_vec_o | output | 8 | Vector byte of the latest raising source |
| sys_stat_o | output | STAT_W (32) | System status word with the pending bit |

## Verification
A vector table covers the register map with the holding register empty. It includes the constant register, unmapped offsets, status reads before and after enable writes, and writes to read-only locations. This separates decode errors from read-mux errors. Directed sequences then push bytes into the holding register. They try to push a second byte while it is full, which distinguishes correct back-pressure from overwrite. They read the data register both full and empty. They raise each interrupt source alone and then both together, which exposes a wrong vector priority. They also write a status register while its source is still active, which separates the clear-then-reassert behaviour from a flag that never clears or never returns.

// File: rtl/con_serial_pkg.sv
package con_serial_pkg;
  localparam int unsigned NUM_REGS = 5;
  localparam int unsigned OFF_RX_STAT = 32'h080;
  localparam int unsigned OFF_RX_DATA = 32'h084;
  localparam int unsigned OFF_TX_STAT = 32'h088;
  localparam int unsigned OFF_TX_DATA = 32'h08C;
  localparam int unsigned OFF_ID      = 32'h100;

  localparam int unsigned BIT_AVAIL = 7;
  localparam int unsigned BIT_IE    = 6;

  localparam logic [7:0] VEC_RX   = 8'hF8;
  localparam logic [7:0] VEC_TX   = 8'hFC;
  localparam int unsigned ID_VALUE = 128;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_RX_STAT = 3'd1,
    SEL_RX_DATA = 3'd2,
    SEL_TX_STAT = 3'd3,
    SEL_TX_DATA = 3'd4,
    SEL_ID      = 3'd5
  } reg_sel_e;

  function automatic int unsigned reg_offset(input int unsigned idx);
    case (idx)
      0:       return OFF_RX_STAT;
      1:       return OFF_RX_DATA;
      2:       return OFF_TX_STAT;
      3:       return OFF_TX_DATA;
      default: return OFF_ID;
    endcase
  endfunction
endpackage

// File: rtl/con_reg_decode.sv
module con_reg_decode
  import con_serial_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    localparam int unsigned OFF = reg_offset(g);
    assign hit[g] = (addr_i == ADDR_W'(OFF));
  end

  always_comb begin
    sel_o = SEL_NONE;
    unique case (1'b1)
      hit[0]:  sel_o = SEL_RX_STAT;
      hit[1]:  sel_o = SEL_RX_DATA;
      hit[2]:  sel_o = SEL_TX_STAT;
      hit[3]:  sel_o = SEL_TX_DATA;
      hit[4]:  sel_o = SEL_ID;
      default: sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/con_rx_hold.sv
module con_rx_hold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              consume_i,
  output logic              full_o,
  output logic [BYTE_W-1:0] data_o
);
  logic full_q;
  logic [BYTE_W-1:0] data_q;

  assign in_ready_o = ~full_q;
  assign full_o     = full_q;
  assign data_o     = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!full_q && in_valid_i) begin
      full_q <= 1'b1;
      data_q <= in_byte_i;
    end else if (full_q && consume_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/con_irq_ctl.sv
module con_irq_ctl
  import con_serial_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_ie_i,
  input  logic       tx_ie_i,
  input  logic       avail_i,
  input  logic       ack_i,
  output logic       pend_o,
  output logic [7:0] vec_o
);
  logic cond_rx, cond_tx;
  logic pend_q;
  logic [7:0] vec_q;

  assign cond_rx = rx_ie_i & avail_i;
  assign cond_tx = tx_ie_i;
  assign pend_o  = pend_q;
  assign vec_o   = vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else if (ack_i) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_q | cond_rx | cond_tx;
      // transmit source wins the vector when both are active
      if (cond_tx)      vec_q <= VEC_TX;
      else if (cond_rx) vec_q <= VEC_RX;
    end
  end
endmodule

// File: rtl/con_serial_regs.sv
module con_serial_regs
  import con_serial_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STAT_W   = 32,
  parameter int unsigned PEND_BIT = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [7:0]        rx_byte_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [7:0]        tx_byte_o,
  output logic              tx_valid_o,
  output logic              irq_o,
  output logic [7:0]        irq_vec_o,
  output logic [STAT_W-1:0] sys_stat_o
);
  localparam int unsigned BYTE_W = 8;

  reg_sel_e sel;
  logic rx_ie_q, tx_ie_q;
  logic full;
  logic [BYTE_W-1:0] hold_data;
  logic consume, ack, pend;
  logic [BYTE_W-1:0] tx_byte_q;
  logic tx_valid_q;
  logic [BYTE_W-1:0] rd_byte;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:BYTE_W];

  con_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  assign consume = bus_rd_i && (sel == SEL_RX_DATA);
  assign ack     = bus_wr_i && ((sel == SEL_RX_STAT) || (sel == SEL_TX_STAT));

  con_rx_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_byte_i  (rx_byte_i),
    .in_valid_i (rx_valid_i),
    .in_ready_o (rx_ready_o),
    .consume_i  (consume),
    .full_o     (full),
    .data_o     (hold_data)
  );

  con_irq_ctl u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_ie_i (rx_ie_q),
    .tx_ie_i (tx_ie_q),
    .avail_i (full),
    .ack_i   (ack),
    .pend_o  (pend),
    .vec_o   (irq_vec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_ie_q    <= 1'b0;
      tx_ie_q    <= 1'b0;
      tx_byte_q  <= '0;
      tx_valid_q <= 1'b0;
    end else begin
      tx_valid_q <= 1'b0;
      if (bus_wr_i) begin
        unique case (sel)
          SEL_RX_STAT: rx_ie_q <= bus_wdata_i[BIT_IE];
          SEL_TX_STAT: tx_ie_q <= bus_wdata_i[BIT_IE];
          SEL_TX_DATA: begin
            tx_byte_q  <= bus_wdata_i[BYTE_W-1:0];
            tx_valid_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_byte_o  = tx_byte_q;
  assign tx_valid_o = tx_valid_q;
  assign irq_o      = pend;

  always_comb begin
    sys_stat_o           = '0;
    sys_stat_o[PEND_BIT] = pend;
  end

  always_comb begin
    rd_byte = '0;
    unique case (sel)
      SEL_RX_STAT: begin
        rd_byte[BIT_AVAIL] = full;
        rd_byte[BIT_IE]    = rx_ie_q;
      end
      SEL_RX_DATA: rd_byte = full ? hold_data : '0;
      SEL_TX_STAT: begin
        rd_byte[BIT_AVAIL] = 1'b1;
        rd_byte[BIT_IE]    = tx_ie_q;
      end
      SEL_ID:      rd_byte = BYTE_W'(ID_VALUE);
      default:     rd_byte = '0;
    endcase
    bus_rdata_o = bus_rd_i ? DATA_W'(rd_byte) : '0;
  end
endmodule

// File: rtl/con_serial_chk.sv
module con_serial_chk
  import con_serial_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STAT_W   = 32,
  parameter int unsigned PEND_BIT = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic [7:0]        tx_byte_o,
  input logic              tx_valid_o,
  input logic              irq_o,
  input logic [7:0]        irq_vec_o,
  input logic [STAT_W-1:0] sys_stat_o
);
  logic rd_data, wr_tx, wr_stat;
  assign rd_data = bus_rd_i && (bus_addr_i == ADDR_W'(OFF_RX_DATA));
  assign wr_tx   = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_TX_DATA));
  assign wr_stat = bus_wr_i && ((bus_addr_i == ADDR_W'(OFF_RX_STAT)) ||
                                (bus_addr_i == ADDR_W'(OFF_TX_STAT)));

  // R3
  rx_full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o) |=> !rx_ready_o);

  // R3
  rx_ready_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ready_o && rd_data) |=> rx_ready_o);

  // R5
  tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx |=> (tx_valid_o && tx_byte_o == $past(bus_wdata_i[7:0])));

  // R5
  tx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_tx |=> !tx_valid_o);

  // R8
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> (!irq_o && sys_stat_o == '0));

  // R6
  vec_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_vec_o == VEC_RX || irq_vec_o == VEC_TX));

  // R4
  tx_ready_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == ADDR_W'(OFF_TX_STAT)) |-> bus_rdata_o[BIT_AVAIL]);

  // R9
  id_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == ADDR_W'(OFF_ID)) |-> bus_rdata_o == DATA_W'(ID_VALUE));
endmodule

bind con_serial_regs con_serial_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W), .PEND_BIT(PEND_BIT)
) u_chk (.*);

// File: tb/tb_con_serial_regs.sv
module tb_con_serial_regs;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 12'h100, 32'h0,        32'h80, 4'd9},   // R9
    '{1'b1, 12'h100, 32'hFF,       32'h0,  4'd9},
    '{1'b0, 12'h100, 32'h0,        32'h80, 4'd9},
    '{1'b0, 12'h200, 32'h0,        32'h0,  4'd10},  // R10
    '{1'b1, 12'h200, 32'hFFFFFFFF, 32'h0,  4'd10},
    '{1'b0, 12'h200, 32'h0,        32'h0,  4'd10},
    '{1'b0, 12'h080, 32'h0,        32'h0,  4'd1},   // R1
    '{1'b0, 12'h088, 32'h0,        32'h80, 4'd4},   // R4
    '{1'b1, 12'h080, 32'hFF,       32'h0,  4'd1},
    '{1'b0, 12'h080, 32'h0,        32'h40, 4'd1},
    '{1'b0, 12'h084, 32'h0,        32'h0,  4'd2},   // R2
    '{1'b1, 12'h080, 32'h0,        32'h0,  4'd1},
    '{1'b0, 12'h080, 32'h0,        32'h0,  4'd1},
    '{1'b1, 12'h084, 32'h55,       32'h0,  4'd2},
    '{1'b0, 12'h084, 32'h0,        32'h0,  4'd2},
    '{1'b0, 12'h088, 32'h0,        32'h80, 4'd4}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic        bus_rd_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [7:0]  rx_byte_i = '0;
  logic        rx_valid_i = 1'b0;
  logic        rx_ready_o;
  logic [7:0]  tx_byte_o;
  logic        tx_valid_o;
  logic        irq_o;
  logic [7:0]  irq_vec_o;
  logic [31:0] sys_stat_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rd_val;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  con_serial_regs dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #1 d = bus_rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_rd_i = 1'b0; bus_addr_i = '0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk_i);
    rx_byte_i = b; rx_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic cycle();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11 irq", 32'(irq_o), 32'h0);
    check("R11 stat", sys_stat_o, 32'h0);
    check("R11 txv", 32'(tx_valid_o), 32'h0);
    check("R11 rdy", 32'(rx_ready_o), 32'h1);
    rst_ni = 1'b1;
    cycle();
    check("R11 rdy after release", 32'(rx_ready_o), 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      if (TBL[i].wr) begin
        bus_write(TBL[i].addr, TBL[i].data);
      end else begin
        bus_read(TBL[i].addr, rd_val);
        check($sformatf("R%0d table %0d", TBL[i].req, i), rd_val, TBL[i].exp);
      end
    end
    check("R10 no irq after table", 32'(irq_o), 32'h0);
    check("R10 no tx after table", 32'(tx_valid_o), 32'h0);

    // R3 / R2 holding register and back-pressure
    push(8'hA5);
    check("R3 ready low when full", 32'(rx_ready_o), 32'h0);
    bus_read(12'h080, rd_val);
    check("R1 avail set", rd_val, 32'h80);
    push(8'h3C);
    bus_read(12'h084, rd_val);
    check("R2 data read", rd_val, 32'hA5);
    check("R3 ready back after read", 32'(rx_ready_o), 32'h1);
    bus_read(12'h084, rd_val);
    check("R2 empty read zero", rd_val, 32'h0);
    bus_read(12'h080, rd_val);
    check("R1 avail clear", rd_val, 32'h0);

    // R5 transmit
    bus_write(12'h08C, 32'h1234_56C3);
    check("R5 tx valid", 32'(tx_valid_o), 32'h1);
    check("R5 tx byte", 32'(tx_byte_o), 32'hC3);
    cycle();
    check("R5 tx single pulse", 32'(tx_valid_o), 32'h0);

    // R6 receive interrupt
    push(8'h11);
    bus_write(12'h080, 32'h40);
    check("R8 ack cycle irq low", 32'(irq_o), 32'h0);
    cycle();
    check("R6 rx irq", 32'(irq_o), 32'h1);
    check("R6 rx vec", 32'(irq_vec_o), 32'hF8);
    check("R8 pending bit", sys_stat_o, 32'h1000_0000);
    bus_read(12'h084, rd_val);
    check("R2 read under irq", rd_val, 32'h11);
    check("R8 pending held", 32'(irq_o), 32'h1);
    bus_write(12'h080, 32'h0);
    check("R8 clear", 32'(irq_o), 32'h0);
    cycle();
    check("R8 stays clear", sys_stat_o, 32'h0);

    // R7 transmit interrupt
    bus_write(12'h088, 32'h40);
    cycle();
    check("R7 tx irq", 32'(irq_o), 32'h1);
    check("R7 tx vec", 32'(irq_vec_o), 32'hFC);
    bus_read(12'h088, rd_val);
    check("R4 tx ie readback", rd_val, 32'hC0);
    bus_write(12'h088, 32'h40);
    check("R8 ack clears while active", 32'(irq_o), 32'h0);
    cycle();
    check("R8 reasserts", 32'(irq_o), 32'h1);

    // R7 both sources: transmit vector wins
    push(8'h22);
    bus_write(12'h080, 32'h40);
    cycle();
    check("R7 both irq", 32'(irq_o), 32'h1);
    check("R7 both vec", 32'(irq_vec_o), 32'hFC);
    bus_write(12'h088, 32'h0);
    cycle();
    check("R6 rx only vec", 32'(irq_vec_o), 32'hF8);
    bus_write(12'h080, 32'h0);
    cycle();
    check("R8 all clear", 32'(irq_o), 32'h0);
    bus_read(12'h084, rd_val);
    check("R2 drain", rd_val, 32'h22);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule